// File: doc/BRIEF.md
# Processor interrupt input conditioner

This block sits between six asynchronous processor input pins and the core's pending-interrupt state. Each pin goes through a synchroniser. The block then compares the synchronised level with the level it stored for that pin. An update that leaves the level unchanged is dropped. A real change is accepted, and the pin's own sensitivity rule decides what it does.

The external and system-management pins are active-high level inputs, and each sets or clears its own pending bit. The machine-check pin reacts only to a falling edge. It latches its pending bit until the core clears that bit. The soft-reset pin drives a pending bit that follows its level. The checkstop and hard-reset pins are active-low level inputs and set no pending bit. Each drives its own request output instead.

A hard-interrupt request output is high whenever any pending bit is set. The core clears pending bits with per-bit acknowledge strobes.

Top module: `irq_input_cond`

## Requirements
- R1: When a pin's synchronised level equals its stored level, that pin changes no pending bit, `stop_req_o` or `hreset_req_o`. A level bit cleared by the core therefore stays clear while its pin holds steady.
- R2: Pins 0 (external) and 1 (system management) are active high. An accepted change on either one copies the new level into pending bit 0 or bit 1.
- R3: Pin 2 (machine check) sets pending bit 2 on an accepted 1-to-0 change. An accepted 0-to-1 change has no effect.
- R4: Pending bit 2 stays set until `clr_i[2]` is pulsed. Later pin changes do not clear it.
- R5: Pin 3 (checkstop) is active low. An accepted change to 0 sets `stop_req_o`, and an accepted change to 1 clears it.
- R6: Pin 4 (hard reset) is active low. An accepted change to 0 sets `hreset_req_o`, and an accepted change to 1 clears it.
- R7: Pin 5 (soft reset) is active high. An accepted change copies its level into pending bit 3.
- R8: `hard_irq_o` is 1 exactly when `pend_o` is non-zero.
- R9: A pulse on `clr_i[k]` clears pending bit k at the next edge. An accepted event on the pin that drives bit k in the same cycle takes priority.
- R10: A pin change reaches the outputs exactly three rising edges after the pin is sampled: two synchroniser stages plus one update stage.
- R11: After reset, all outputs are 0. The stored levels hold the inactive values, which are 1 for pins 2, 3 and 4 and 0 for the others. A pin held active through reset release therefore produces one accepted event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 6 | Raw pins: 0 ext, 1 smi, 2 mchk, 3 checkstop_n, 4 hreset_n, 5 soft reset |
| clr_i | input | 4 | Per-bit pending clear strobes |
| pend_o | output | 4 | Pending bits: 0 ext, 1 smi, 2 mchk, 3 soft reset |
| hard_irq_o | output | 1 | Any pending bit set |
| stop_req_o | output | 1 | Processor stop request |
| hreset_req_o | output | 1 | Processor hard-reset request |

## Verification
The bench goes after four corner cases.

- **Machine-check rising edge.** The bench drives a rising edge on the machine-check pin after a falling one. A design that treated this pin as a level input would drop the latched bit.
- **Clear while a level pin is held high.** The bench clears a level bit while its pin stays high. A design without the change filter would set the bit again on the next cycle.
- **Exact latency.** The bench checks the output one edge before and at the third edge. A synchroniser that is one stage short or one stage long fails this check.
- **Event and clear in the same cycle.** Random clears that land in the same cycle as pin events exercise this priority. A design that gave the clear priority would lose the event.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_PINS = 6;
  localparam int NUM_PEND = 4;

  localparam int PIN_EXT   = 0;
  localparam int PIN_SMI   = 1;
  localparam int PIN_MCHK  = 2;
  localparam int PIN_STOPN = 3;
  localparam int PIN_HRSTN = 4;
  localparam int PIN_SRST  = 5;

  localparam int SLOT_EXT  = 0;
  localparam int SLOT_SMI  = 1;
  localparam int SLOT_MCHK = 2;
  localparam int SLOT_SRST = 3;

  // inactive level per pin, also the reset value of every stored level
  localparam logic [NUM_PINS-1:0] PIN_IDLE = 6'b011100;

  typedef enum logic [1:0] {SENS_HIGH, SENS_LOW, SENS_FALL} sens_e;

  function automatic sens_e pin_sens(input int idx);
    case (idx)
      PIN_MCHK:             return SENS_FALL;
      PIN_STOPN, PIN_HRSTN: return SENS_LOW;
      default:              return SENS_HIGH;
    endcase
  endfunction

  // pin that drives each pending slot
  function automatic int slot_pin(input int slot);
    case (slot)
      SLOT_EXT:  return PIN_EXT;
      SLOT_SMI:  return PIN_SMI;
      SLOT_MCHK: return PIN_MCHK;
      default:   return PIN_SRST;
    endcase
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int WIDTH = 6,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_change_det.sv
module irqc_change_det #(
  parameter int WIDTH = 6,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] prev_o,
  output logic [WIDTH-1:0] chg_o
);
  // stored level is rewritten each cycle; it only moves on an accepted change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_o <= RST_VAL;
    else prev_o <= lvl_i;
  end

  assign chg_o = lvl_i ^ prev_o;
endmodule

// File: rtl/irqc_classify.sv
module irqc_classify
  import irqc_pkg::*;
(
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] chg_i,
  output logic [NUM_PINS-1:0] assert_o,
  output logic [NUM_PINS-1:0] deassert_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam sens_e KIND = pin_sens(i);
    if (KIND == SENS_HIGH) begin : g_high
      assign assert_o[i]   = chg_i[i] &  lvl_i[i];
      assign deassert_o[i] = chg_i[i] & ~lvl_i[i];
    end else if (KIND == SENS_LOW) begin : g_low
      assign assert_o[i]   = chg_i[i] & ~lvl_i[i];
      assign deassert_o[i] = chg_i[i] &  lvl_i[i];
    end else begin : g_fall
      assign assert_o[i]   = chg_i[i] & ~lvl_i[i];
      assign deassert_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_input_cond.sv
module irq_input_cond
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PEND-1:0] clr_i,
  output logic [NUM_PEND-1:0] pend_o,
  output logic                hard_irq_o,
  output logic                stop_req_o,
  output logic                hreset_req_o
);
  logic [NUM_PINS-1:0] lvl, prev, chg, act_set, act_clr;
  logic [NUM_PEND-1:0] pend_nx;

  irqc_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(lvl));

  irqc_change_det #(.WIDTH(NUM_PINS), .RST_VAL(PIN_IDLE)) u_chg (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .prev_o(prev), .chg_o(chg));

  irqc_classify u_cls (
    .lvl_i(lvl), .chg_i(chg), .assert_o(act_set), .deassert_o(act_clr));

  for (genvar k = 0; k < NUM_PEND; k++) begin : g_slot
    localparam int P = slot_pin(k);
    always_comb begin
      if (act_set[P])      pend_nx[k] = 1'b1;
      else if (act_clr[P]) pend_nx[k] = 1'b0;
      else if (clr_i[k])   pend_nx[k] = 1'b0;
      else                 pend_nx[k] = pend_o[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o       <= '0;
      hard_irq_o   <= 1'b0;
      stop_req_o   <= 1'b0;
      hreset_req_o <= 1'b0;
    end else begin
      pend_o     <= pend_nx;
      hard_irq_o <= |pend_nx;
      if (act_set[PIN_STOPN])      stop_req_o <= 1'b1;
      else if (act_clr[PIN_STOPN]) stop_req_o <= 1'b0;
      if (act_set[PIN_HRSTN])      hreset_req_o <= 1'b1;
      else if (act_clr[PIN_HRSTN]) hreset_req_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] lvl,
  input logic [NUM_PINS-1:0] prev,
  input logic [NUM_PEND-1:0] clr_i,
  input logic [NUM_PEND-1:0] pend_o,
  input logic                hard_irq_o,
  input logic                stop_req_o,
  input logic                hreset_req_o
);
  // R1
  steady_pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == prev && clr_i == '0) |=> ($stable(pend_o) && $stable(stop_req_o) && $stable(hreset_req_o)));

  // R2
  ext_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl[PIN_EXT] != prev[PIN_EXT]) |=> (pend_o[SLOT_EXT] == $past(lvl[PIN_EXT])));

  // R3
  mchk_fall_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev[PIN_MCHK] && !lvl[PIN_MCHK]) |=> pend_o[SLOT_MCHK]);

  // R4
  mchk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o[SLOT_MCHK] && !clr_i[SLOT_MCHK]) |=> pend_o[SLOT_MCHK]);

  // R5
  stop_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl[PIN_STOPN] != prev[PIN_STOPN]) |=> (stop_req_o == !$past(lvl[PIN_STOPN])));

  // R6
  hreset_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl[PIN_HRSTN] != prev[PIN_HRSTN]) |=> (hreset_req_o == !$past(lvl[PIN_HRSTN])));

  // R8
  hard_irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_irq_o == (pend_o != '0));
endmodule

bind irq_input_cond irqc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .lvl(lvl), .prev(prev), .clr_i(clr_i),
  .pend_o(pend_o), .hard_irq_o(hard_irq_o), .stop_req_o(stop_req_o),
  .hreset_req_o(hreset_req_o));

// File: tb/test_irq_input_cond.sv
module test_irq_input_cond;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] pin_i = 6'b011100;
  logic [3:0] clr_i = '0;
  logic [3:0] pend_o;
  logic       hard_irq_o, stop_req_o, hreset_req_o;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  irq_input_cond i_irq_input_cond (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .clr_i(clr_i), .pend_o(pend_o),
    .hard_irq_o(hard_irq_o), .stop_req_o(stop_req_o), .hreset_req_o(hreset_req_o));

  // reference model built from the requirements
  logic [5:0] m_s1, m_s2, m_prev;
  logic [3:0] m_pend;
  logic       m_stop, m_hrst;

  function automatic logic [3:0] next_pend(input logic [3:0] p, input logic [5:0] lv,
                                           input logic [5:0] pv, input logic [3:0] c);
    logic [3:0] n = p;
    logic [5:0] ev = lv ^ pv;
    for (int k = 0; k < 4; k++) if (c[k]) n[k] = 1'b0;
    if (ev[0]) n[0] = lv[0];                 // R2
    if (ev[1]) n[1] = lv[1];                 // R2
    if (ev[2] && !lv[2]) n[2] = 1'b1;        // R3
    else if (ev[2]) n[2] = p[2] & ~c[2];     // R3 rising edge: no event
    if (ev[5]) n[3] = lv[5];                 // R7
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 6'b011100; m_s2 <= 6'b011100; m_prev <= 6'b011100;
      m_pend <= '0; m_stop <= 1'b0; m_hrst <= 1'b0;
    end else begin
      m_pend <= next_pend(m_pend, m_s2, m_prev, clr_i);
      if (m_s2[3] != m_prev[3]) m_stop <= !m_s2[3];
      if (m_s2[4] != m_prev[4]) m_hrst <= !m_s2[4];
      m_prev <= m_s2; m_s2 <= m_s1; m_s1 <= pin_i;
    end
  end

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic model_on = 1'b0;
  always @(negedge clk) if (model_on && rst_n) begin
    check("R2/R3/R7/R9 pend", pend_o, m_pend);
    check("R5 stop", {3'b0, stop_req_o}, {3'b0, m_stop});
    check("R6 hreset", {3'b0, hreset_req_o}, {3'b0, m_hrst});
    check("R8 hard_irq", {3'b0, hard_irq_o}, {3'b0, |m_pend});
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    step(3);
    rst_n = 1'b1;
    // R11 reset state
    check("R11 reset outputs", {pend_o == 4'd0, hard_irq_o, stop_req_o, hreset_req_o}, 4'b1000);
    model_on = 1'b1;
    step(2);
    // R10 latency
    pin_i[0] = 1'b1;
    step(2);
    check("R10 before third edge", {3'b0, pend_o[0]}, 4'd0);
    step(1);
    check("R10 at third edge", {3'b0, pend_o[0]}, 4'd1);
    check("R8 hard irq set", {3'b0, hard_irq_o}, 4'd1);
    // R1 and R9: clear while pin held high stays clear
    clr_i[0] = 1'b1; step(1); clr_i[0] = 1'b0;
    check("R9 clear ext", {3'b0, pend_o[0]}, 4'd0);
    step(5);
    check("R1 steady pin no reset of bit", {3'b0, pend_o[0]}, 4'd0);
    check("R8 hard irq clear", {3'b0, hard_irq_o}, 4'd0);
    pin_i[0] = 1'b0; step(4);
    // R3 and R4 machine check
    pin_i[2] = 1'b0; step(3);
    check("R3 fall sets", {3'b0, pend_o[2]}, 4'd1);
    pin_i[2] = 1'b1; step(4);
    check("R3 rise ignored", {3'b0, pend_o[2]}, 4'd1);
    check("R4 sticky", {3'b0, pend_o[2]}, 4'd1);
    clr_i[2] = 1'b1; step(1); clr_i[2] = 1'b0;
    check("R4 cleared by strobe", {3'b0, pend_o[2]}, 4'd0);
    // R5 checkstop
    pin_i[3] = 1'b0; step(3);
    check("R5 stop set", {3'b0, stop_req_o}, 4'd1);
    pin_i[3] = 1'b1; step(3);
    check("R5 stop released", {3'b0, stop_req_o}, 4'd0);
    // R6 hard reset
    pin_i[4] = 1'b0; step(3);
    check("R6 hreset set", {3'b0, hreset_req_o}, 4'd1);
    pin_i[4] = 1'b1; step(3);
    check("R6 hreset released", {3'b0, hreset_req_o}, 4'd0);
    // R7 soft reset
    pin_i[5] = 1'b1; step(3);
    check("R7 soft reset set", {3'b0, pend_o[3]}, 4'd1);
    pin_i[5] = 1'b0; step(3);
    check("R7 soft reset clear", {3'b0, pend_o[3]}, 4'd0);
    // R2 smi
    pin_i[1] = 1'b1; step(3);
    check("R2 smi set", {3'b0, pend_o[1]}, 4'd1);
    pin_i[1] = 1'b0; step(3);
    check("R2 smi clear", {3'b0, pend_o[1]}, 4'd0);
    // random mix, checked every cycle by the model
    for (int c = 0; c < 4000; c++) begin
      for (int b = 0; b < 6; b++) if ($urandom_range(7) == 0) pin_i[b] = ~pin_i[b];
      for (int b = 0; b < 4; b++) clr_i[b] = ($urandom_range(11) == 0);
      step(1);
    end
    clr_i = '0;
    // R11 active pin through reset release produces an event
    rst_n = 1'b0; model_on = 1'b0;
    pin_i = 6'b000000;
    step(2);
    rst_n = 1'b1;
    check("R11 outputs in reset", {pend_o[2], stop_req_o, hreset_req_o, 1'b0}, 4'd0);
    step(3);
    check("R11 active pins at release", {pend_o[2], stop_req_o, hreset_req_o, 1'b0}, 4'b1110);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule